// File: doc/BRIEF.md
# Interrupt Destination Matcher with Rotating Lowest-Priority Pick

This block takes one inter-processor interrupt command per cycle and decides which of `N` target units accept it. A command carries an 8-bit destination, a 2-bit shorthand, a physical/logical addressing flag, a lowest-priority flag and the index of the sending unit.

Each target is described by an 8-bit physical ID, an 8-bit logical ID, a present flag and an enable flag. Each target also has a 4-bit destination-format code, which is held inside the block and written through a small write port. For ordinary delivery, every target that matches and is present and enabled is asserted at once. For lowest-priority delivery, exactly one of those targets is chosen by a rotating pointer.

The result is registered. It appears as an accept vector together with a one-cycle valid strobe, one clock after the command.

Top module: `irq_dest_router`

## Requirements
- R1: With shorthand 0 and `cmdLogical`=0, target i matches when `cmdDest` is 8'hFF or equals its physical ID.
- R2: With shorthand 0 and `cmdLogical`=1, a target whose format code is 4'hF (flat) matches when the bitwise AND of its logical ID and `cmdDest` is nonzero.
- R3: With shorthand 0 and `cmdLogical`=1, a target whose format code is 4'h0 (cluster) matches when bits [7:4] of logical ID and `cmdDest` are equal and the AND of their bits [3:0] is nonzero.
- R4: In logical mode, a target whose format code is neither 4'hF nor 4'h0 never matches.
- R5: Shorthand 1 matches only the target whose index equals `cmdSender`. Shorthand 2 matches every target. Shorthand 3 matches every target except the sender. Under any nonzero shorthand, `cmdDest` and `cmdLogical` have no effect.
- R6: With `cmdLowest`=0, the accept vector holds every target that matches and has both `tgtPresent` and `tgtEnable` set. A target lacking either flag is never accepted.
- R7: With `cmdLowest`=1, exactly one candidate (a matching, present, enabled target) is accepted. The search starts at the pointer plus one, wraps at N and takes the first candidate found. The pointer then moves to that index. The pointer resets to 0.
- R8: With `cmdLowest`=1 and no candidate, the accept vector is zero and the pointer stays where it was.
- R9: Every format code resets to 4'hF (flat). A write with `fmtWrEn`=1 stores `fmtWrNib` into the format code of target `fmtWrIdx` for use from the next cycle on.
- R10: `acceptValid` pulses high for exactly the cycle after each cycle with `cmdValid`=1. At all other times `acceptValid` and `acceptVec` are zero, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdDest | input | 8 | Destination field |
| cmdShort | input | 2 | Shorthand: 0 none, 1 self, 2 all, 3 all but sender |
| cmdLogical | input | 1 | 1 = logical addressing, 0 = physical |
| cmdLowest | input | 1 | 1 = lowest-priority (single target) delivery |
| cmdSender | input | $clog2(N) | Index of the sending unit |
| tgtPhysId | input | 8*N | Physical IDs, target i in bits [8i+7:8i] |
| tgtLogId | input | 8*N | Logical IDs, target i in bits [8i+7:8i] |
| tgtPresent | input | N | Target exists |
| tgtEnable | input | N | Target is enabled |
| fmtWrEn | input | 1 | Write a format code |
| fmtWrIdx | input | $clog2(N) | Target whose format code is written |
| fmtWrNib | input | 4 | New format code |
| acceptVec | output | N | Targets accepting the command |
| acceptValid | output | 1 | Result strobe |

## Verification
Physical commands are tried with an exact ID, the broadcast value and an unused ID. These separate the equality test from the broadcast override. Logical commands are sent under flat codes, cluster codes and an undefined code, with destinations chosen so that the cluster compare and the lower-nibble AND each reject some targets. This shows that the format code is read per target. Lowest-priority streams are run with full, sparse and empty candidate sets, so that wraparound, skipping and the pointer holding on an empty set all show up in the order of the chosen targets.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int ID_W = 8;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic loadOut;
    logic selLowest;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_dest_ctrl.sv
module irq_dest_ctrl
  import irq_dest_pkg::*;
#(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic            cmdLowest,
  input  logic [N-1:0]    candVec,
  output ctrlStrobe_t     strobe,
  output logic [N-1:0]    pickVec
);
  logic [IDXW-1:0] rrPtr;
  logic [IDXW-1:0] stopIdx;
  logic            found;

  // rotating search: ptr+1, ptr+2, ... wrapping, ending on ptr itself
  always_comb begin
    found   = 1'b0;
    stopIdx = rrPtr;
    pickVec = '0;
    for (int k = 1; k <= N; k++) begin
      logic [IDXW-1:0] idx;
      idx = IDXW'((int'(rrPtr) + k) % N);
      if (!found && candVec[idx]) begin
        found   = 1'b1;
        stopIdx = idx;
      end
    end
    if (found) pickVec[stopIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rrPtr <= '0;
    else if (cmdValid && cmdLowest) rrPtr <= stopIdx;
  end

  always_comb begin
    strobe.loadOut   = cmdValid;
    strobe.selLowest = cmdLowest;
  end

  // R7
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pickVec) && ((pickVec & ~candVec) == '0));
  // R7
  pick_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (candVec != '0) |-> (pickVec != '0));
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdLowest && (candVec != '0)) |=> $stable(rrPtr));
endmodule

// File: rtl/irq_dest_dp.sv
module irq_dest_dp
  import irq_dest_pkg::*;
#(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   cmdDest,
  input  logic [1:0]        cmdShort,
  input  logic              cmdLogical,
  input  logic [IDXW-1:0]   cmdSender,
  input  logic [N*ID_W-1:0] tgtPhysId,
  input  logic [N*ID_W-1:0] tgtLogId,
  input  logic [N-1:0]      tgtPresent,
  input  logic [N-1:0]      tgtEnable,
  input  logic              fmtWrEn,
  input  logic [IDXW-1:0]   fmtWrIdx,
  input  logic [3:0]        fmtWrNib,
  input  ctrlStrobe_t       strobe,
  input  logic [N-1:0]      pickVec,
  output logic [N-1:0]      candVec,
  output logic [N-1:0]      acceptVec,
  output logic              acceptValid
);
  logic [N-1:0] matchVec;
  logic [3:0]   fmtQ [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_tgt
    logic [ID_W-1:0] physId;
    logic [ID_W-1:0] logId;
    logic            logHit;
    logic            hit;

    assign physId = tgtPhysId[gi*ID_W +: ID_W];
    assign logId  = tgtLogId[gi*ID_W +: ID_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) fmtQ[gi] <= FMT_FLAT;
      else if (fmtWrEn && fmtWrIdx == IDXW'(gi)) fmtQ[gi] <= fmtWrNib;
    end

    always_comb begin
      unique case (fmtQ[gi])
        FMT_FLAT:    logHit = |(logId & cmdDest);
        FMT_CLUSTER: logHit = (logId[7:4] == cmdDest[7:4]) && |(logId[3:0] & cmdDest[3:0]);
        default:     logHit = 1'b0;
      endcase
    end

    always_comb begin
      unique case (shorthand_e'(cmdShort))
        SH_NONE:   hit = cmdLogical ? logHit : ((cmdDest == 8'hFF) || (cmdDest == physId));
        SH_SELF:   hit = (cmdSender == IDXW'(gi));
        SH_ALL:    hit = 1'b1;
        SH_OTHERS: hit = (cmdSender != IDXW'(gi));
        default:   hit = 1'b0;
      endcase
    end

    assign matchVec[gi] = hit;

    // R9
    fmt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fmtWrEn && fmtWrIdx == IDXW'(gi)) |=> (fmtQ[gi] == $past(fmtWrNib)));
  end

  assign candVec = matchVec & tgtPresent & tgtEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptVec   <= '0;
      acceptValid <= 1'b0;
    end else if (strobe.loadOut) begin
      acceptVec   <= strobe.selLowest ? pickVec : candVec;
      acceptValid <= 1'b1;
    end else begin
      acceptVec   <= '0;
      acceptValid <= 1'b0;
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |=> acceptValid);
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acceptValid |-> (acceptVec == '0));
  // R6
  accept_allowed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |=> ((acceptVec & ~$past(tgtPresent & tgtEnable)) == '0));
endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router
  import irq_dest_pkg::*;
#(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdDest,
  input  logic [1:0]        cmdShort,
  input  logic              cmdLogical,
  input  logic              cmdLowest,
  input  logic [IDXW-1:0]   cmdSender,
  input  logic [N*8-1:0]    tgtPhysId,
  input  logic [N*8-1:0]    tgtLogId,
  input  logic [N-1:0]      tgtPresent,
  input  logic [N-1:0]      tgtEnable,
  input  logic              fmtWrEn,
  input  logic [IDXW-1:0]   fmtWrIdx,
  input  logic [3:0]        fmtWrNib,
  output logic [N-1:0]      acceptVec,
  output logic              acceptValid
);
  ctrlStrobe_t  strobe;
  logic [N-1:0] candVec;
  logic [N-1:0] pickVec;

  irq_dest_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdLowest (cmdLowest),
    .candVec   (candVec),
    .strobe    (strobe),
    .pickVec   (pickVec)
  );

  irq_dest_dp #(.N(N)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmdDest     (cmdDest),
    .cmdShort    (cmdShort),
    .cmdLogical  (cmdLogical),
    .cmdSender   (cmdSender),
    .tgtPhysId   (tgtPhysId),
    .tgtLogId    (tgtLogId),
    .tgtPresent  (tgtPresent),
    .tgtEnable   (tgtEnable),
    .fmtWrEn     (fmtWrEn),
    .fmtWrIdx    (fmtWrIdx),
    .fmtWrNib    (fmtWrNib),
    .strobe      (strobe),
    .pickVec     (pickVec),
    .candVec     (candVec),
    .acceptVec   (acceptVec),
    .acceptValid (acceptValid)
  );
endmodule

// File: tb/irq_dest_router_bench.sv
`timescale 1ns/1ps
module irq_dest_router_bench;
  localparam int N = 4;
  localparam int IDXW = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdValid = 1'b0;
  logic [7:0]      cmdDest = '0;
  logic [1:0]      cmdShort = '0;
  logic            cmdLogical = 1'b0;
  logic            cmdLowest = 1'b0;
  logic [IDXW-1:0] cmdSender = '0;
  logic [N*8-1:0]  tgtPhysId;
  logic [N*8-1:0]  tgtLogId;
  logic [N-1:0]    tgtPresent = '1;
  logic [N-1:0]    tgtEnable = '1;
  logic            fmtWrEn = 1'b0;
  logic [IDXW-1:0] fmtWrIdx = '0;
  logic [3:0]      fmtWrNib = '0;
  logic [N-1:0]    acceptVec;
  logic            acceptValid;

  irq_dest_router #(.N(N)) u_irq_dest_router (.*);

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  logic [N-1:0] expQ[$];
  string        tagQ[$];
  logic [3:0]   fmtModel [N];
  int           ptrModel = 0;
  bit           finished = 1'b0;

  function automatic logic modelHit(int i, logic [7:0] d, logic [1:0] sh, logic lg, int snd);
    logic [7:0] pid, lid;
    pid = tgtPhysId[i*8 +: 8];
    lid = tgtLogId[i*8 +: 8];
    case (sh)
      2'd1: return i == snd;
      2'd2: return 1'b1;
      2'd3: return i != snd;
      default: begin
        if (!lg) return (d == 8'hFF) || (d == pid);
        if (fmtModel[i] == 4'hF) return (lid & d) != 0;
        if (fmtModel[i] == 4'h0) return (lid[7:4] == d[7:4]) && ((lid[3:0] & d[3:0]) != 0);
        return 1'b0;
      end
    endcase
  endfunction

  task automatic issue(logic [7:0] d, logic [1:0] sh, logic lg, logic low, int snd, string tag);
    logic [N-1:0] cand, exp;
    cand = '0;
    for (int i = 0; i < N; i++)
      cand[i] = modelHit(i, d, sh, lg, snd) & tgtPresent[i] & tgtEnable[i];
    exp = cand;
    if (low) begin
      exp = '0;
      for (int k = 1; k <= N; k++) begin
        int idx;
        idx = (ptrModel + k) % N;
        if (exp == '0 && cand[idx]) begin
          exp[idx] = 1'b1;
          ptrModel = idx;
        end
      end
    end
    cmdDest = d; cmdShort = sh; cmdLogical = lg; cmdLowest = low;
    cmdSender = IDXW'(snd); cmdValid = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic writeFmt(int idx, logic [3:0] nib);
    fmtWrEn = 1'b1; fmtWrIdx = IDXW'(idx); fmtWrNib = nib;
    @(negedge clk);
    fmtWrEn = 1'b0;
    fmtModel[idx] = nib;
  endtask

  // monitor: pops one expected item per result strobe
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (acceptValid) begin
        nChecks++;
        if (expQ.size() == 0) begin
          nFails++;
          $display("FAIL R10: unexpected strobe, vec=%b expected no result", acceptVec);
        end else begin
          logic [N-1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (acceptVec !== e) begin
            nFails++;
            $display("FAIL %s: acceptVec=%b expected %b", t, acceptVec, e);
          end
        end
      end else if (acceptVec !== '0) begin
        nChecks++;
        nFails++;
        $display("FAIL R10: acceptVec=%b while idle, expected 0", acceptVec);
      end
    end
  end

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) fmtModel[i] = 4'hF;
    tgtPhysId = {8'h13, 8'h12, 8'h11, 8'h10};
    tgtLogId  = {8'h88, 8'h04, 8'h02, 8'h01};
    repeat (3) @(negedge clk);
    nChecks++;
    if (acceptValid !== 1'b0 || acceptVec !== '0) begin
      nFails++;
      $display("FAIL R10: reset outputs valid=%b vec=%b expected 0/0000", acceptValid, acceptVec);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R1 physical
    issue(8'h12, 2'd0, 1'b0, 1'b0, 0, "R1");
    issue(8'hFF, 2'd0, 1'b0, 1'b0, 0, "R1");
    issue(8'h55, 2'd0, 1'b0, 1'b0, 0, "R1");
    // R2 flat (reset format code)
    issue(8'h05, 2'd0, 1'b1, 1'b0, 0, "R2");
    issue(8'h80, 2'd0, 1'b1, 1'b0, 0, "R2");
    // R9 + R3 cluster
    for (int i = 0; i < N; i++) writeFmt(i, 4'h0);
    tgtLogId = {8'h23, 8'h31, 8'h22, 8'h21};
    issue(8'h23, 2'd0, 1'b1, 1'b0, 0, "R3");
    issue(8'h31, 2'd0, 1'b1, 1'b0, 0, "R3");
    issue(8'h28, 2'd0, 1'b1, 1'b0, 0, "R3");
    // R4 undefined format on target 1
    writeFmt(1, 4'h5);
    issue(8'h23, 2'd0, 1'b1, 1'b0, 0, "R4");
    // R9: back to flat on target 1
    writeFmt(1, 4'hF);
    issue(8'h02, 2'd0, 1'b1, 1'b0, 0, "R9");
    // R5 shorthands, destination ignored
    issue(8'h00, 2'd1, 1'b1, 1'b0, 2, "R5");
    issue(8'h00, 2'd2, 1'b0, 1'b0, 2, "R5");
    issue(8'h12, 2'd3, 1'b0, 1'b0, 2, "R5");
    // R6 present/enable
    tgtEnable = 4'b0111;
    issue(8'hFF, 2'd2, 1'b0, 1'b0, 0, "R6");
    tgtPresent = 4'b1101; tgtEnable = 4'b1111;
    issue(8'hFF, 2'd0, 1'b0, 1'b0, 0, "R6");
    tgtPresent = 4'b1111;
    // R7 rotation over full set then sparse
    for (int r = 0; r < 5; r++) issue(8'h00, 2'd2, 1'b0, 1'b1, 0, "R7");
    tgtEnable = 4'b0101;
    for (int r = 0; r < 3; r++) issue(8'h00, 2'd2, 1'b0, 1'b1, 0, "R7");
    tgtEnable = 4'b1111;
    // R8 empty candidate set keeps the pointer
    issue(8'h77, 2'd0, 1'b0, 1'b1, 0, "R8");
    issue(8'h00, 2'd2, 1'b0, 1'b1, 0, "R8");
    issue(8'h00, 2'd2, 1'b0, 1'b1, 0, "R8");
    // R10 idle cycles produce nothing
    repeat (4) @(negedge clk);

    finished = 1'b1;
    while (expQ.size() != 0) begin
      string t;
      t = tagQ.pop_front();
      void'(expQ.pop_front());
      nChecks++;
      nFails++;
      $display("FAIL %s: no result seen, expected one", t);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule